// File: doc/BRIEF.md
# Register File with Hardwired Constant Rows

This block holds the general-purpose registers of a small RISC core: eight 16-bit rows addressed by 3-bit indices. Two source operands come out of two independent combinational read ports in the same cycle. Results go in through one write port that is registered on the rising clock edge.

The two lowest rows are not storage. Row 0 always returns zero and row 1 always returns one, so software can get both constants without loading them first. Any write aimed at either row is discarded. The write port takes a 2-bit mode code. The code can write the whole word, or only one byte lane while the other lane keeps its value. The byte modes serve instructions that load an 8-bit immediate into one half of a register. An active-high synchronous reset clears every writable row.

Top module: `rf_const_regfile`

## Requirements
- R1: With default parameters the file has 8 rows of 16 bits. The two read ports are combinational and independent: each port returns the row selected by its own 3-bit address in the same cycle.
- R2: Reading address 0 on either port always returns 0x0000. Writes of any mode to address 0 have no effect.
- R3: Reading address 1 on either port always returns 0x0001. Writes of any mode to address 1 have no effect.
- R4: Write mode code 2'b00 performs no write. Every row keeps its value.
- R5: Write mode code 2'b01 stores all 16 bits of the write data into the row at the write address (rows 2 to 7) on the rising clock edge.
- R6: Write mode code 2'b10 stores write data bits [7:0] into bits [7:0] of the addressed row. Bits [15:8] of that row are unchanged.
- R7: Write mode code 2'b11 stores write data bits [15:8] into bits [15:8] of the addressed row. Bits [7:0] of that row are unchanged.
- R8: A read of a row in the same cycle that the row is written returns the value from before the write. The new value is visible from the next cycle on.
- R9: When reset is high at a rising edge, rows 2 to 7 become 0x0000. Reset takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wrMode | input | 2 | Write mode: 00 none, 01 word, 10 low byte, 11 high byte |
| wrAddr | input | 3 | Destination row index |
| wrData | input | 16 | Write data |
| rdAddrA | input | 3 | Row index for read port A |
| rdDataA | output | 16 | Read port A data |
| rdAddrB | input | 3 | Row index for read port B |
| rdDataB | output | 16 | Read port B data |

## Verification
The bench builds the block with its default parameters: 16-bit rows, eight rows and two constant rows. With these values the 3-bit addresses cover every row, both constant rows and both byte lanes, so every address and every mode can be driven exhaustively. A behavioural model predicts both read ports before each edge. This checks the read-old-value timing, the lane masking on partial writes, writes discarded at rows 0 and 1, and reset winning over a simultaneous write.

// File: rtl/rf_pkg.sv
package rf_pkg;

  // Write mode encoding seen on the wrMode port
  typedef enum logic [1:0] {
    WR_IDLE = 2'b00,
    WR_WORD = 2'b01,
    WR_LOW  = 2'b10,
    WR_HIGH = 2'b11
  } wrMode_e;

  // Lane strobes handed from control to datapath
  typedef struct packed {
    logic loLane;
    logic hiLane;
  } laneStrobe_t;

endpackage

// File: rtl/rf_ctrl.sv
module rf_ctrl #(
  parameter int NUM_REGS   = 8,
  parameter int CONST_REGS = 2,
  parameter int ADDR_W     = $clog2(NUM_REGS)
) (
  input  logic                    rst,
  input  logic [1:0]              wrMode,
  input  logic [ADDR_W-1:0]       wrAddr,
  output logic [NUM_REGS-1:0]     rowWe,
  output rf_pkg::laneStrobe_t     lanes,
  output logic                    clearAll
);
  import rf_pkg::*;

  localparam logic [ADDR_W-1:0] FIRST_RW = ADDR_W'(CONST_REGS);

  always_comb begin
    lanes = '0;
    unique case (wrMode)
      WR_WORD: begin lanes.loLane = 1'b1; lanes.hiLane = 1'b1; end
      WR_LOW:  lanes.loLane = 1'b1;
      WR_HIGH: lanes.hiLane = 1'b1;
      default: lanes = '0;
    endcase
  end

  // Row select: suppressed for the hardwired rows
  always_comb begin
    rowWe = '0;
    if ((lanes.loLane || lanes.hiLane) && (wrAddr >= FIRST_RW))
      rowWe[wrAddr] = 1'b1;
  end

  assign clearAll = rst;

endmodule

// File: rtl/rf_data.sv
module rf_data #(
  parameter int DATA_W     = 16,
  parameter int NUM_REGS   = 8,
  parameter int CONST_REGS = 2,
  parameter int ADDR_W     = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  clearAll,
  input  logic [NUM_REGS-1:0]   rowWe,
  input  rf_pkg::laneStrobe_t   lanes,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [ADDR_W-1:0]     rdAddrA,
  input  logic [ADDR_W-1:0]     rdAddrB,
  output logic [DATA_W-1:0]     rdDataA,
  output logic [DATA_W-1:0]     rdDataB
);

  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] rowQ [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
    if (r < CONST_REGS) begin : g_const
      // Hardwired row: reads back its own index
      assign rowQ[r] = DATA_W'(r);
    end else begin : g_store
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (clearAll) begin
          q <= '0;
        end else if (rowWe[r]) begin
          if (lanes.loLane) q[HALF-1:0]      <= wrData[HALF-1:0];
          if (lanes.hiLane) q[DATA_W-1:HALF] <= wrData[DATA_W-1:HALF];
        end
      end
      assign rowQ[r] = q;
    end
  end

  assign rdDataA = rowQ[rdAddrA];
  assign rdDataB = rowQ[rdAddrB];

endmodule

// File: rtl/rf_const_regfile.sv
module rf_const_regfile #(
  parameter int DATA_W     = 16,
  parameter int NUM_REGS   = 8,
  parameter int CONST_REGS = 2,
  parameter int ADDR_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        wrMode,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB
);

  logic [NUM_REGS-1:0] rowWe;
  rf_pkg::laneStrobe_t lanes;
  logic                clearAll;

  rf_ctrl #(
    .NUM_REGS(NUM_REGS), .CONST_REGS(CONST_REGS), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .rst(rst), .wrMode(wrMode), .wrAddr(wrAddr),
    .rowWe(rowWe), .lanes(lanes), .clearAll(clearAll)
  );

  rf_data #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .CONST_REGS(CONST_REGS), .ADDR_W(ADDR_W)
  ) u_data (
    .clk(clk), .clearAll(clearAll), .rowWe(rowWe), .lanes(lanes),
    .wrData(wrData), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .rdDataA(rdDataA), .rdDataB(rdDataB)
  );

endmodule

// File: rtl/rf_const_regfile_chk.sv
module rf_const_regfile_chk #(
  parameter int DATA_W     = 16,
  parameter int NUM_REGS   = 8,
  parameter int CONST_REGS = 2,
  parameter int ADDR_W     = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        wrMode,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [ADDR_W-1:0] rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [ADDR_W-1:0] rdAddrB,
  input logic [DATA_W-1:0] rdDataB
);

  localparam int HALF = DATA_W / 2;
  localparam logic [ADDR_W-1:0] FIRST_RW = ADDR_W'(CONST_REGS);

  AST_ZERO_ROW_A: assert property (@(posedge clk) disable iff (rst)
    (rdAddrA == '0) |-> (rdDataA == '0)); // R2
  AST_ZERO_ROW_B: assert property (@(posedge clk) disable iff (rst)
    (rdAddrB == '0) |-> (rdDataB == '0)); // R2
  AST_ONE_ROW_A: assert property (@(posedge clk) disable iff (rst)
    (rdAddrA == ADDR_W'(1)) |-> (rdDataA == DATA_W'(1))); // R3
  AST_ONE_ROW_B: assert property (@(posedge clk) disable iff (rst)
    (rdAddrB == ADDR_W'(1)) |-> (rdDataB == DATA_W'(1))); // R3
  AST_WORD_LANDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wrMode) == 2'b01 && $past(wrAddr) >= FIRST_RW
     && rdAddrA == $past(wrAddr)) |-> (rdDataA == $past(wrData))); // R5
  AST_LOW_LANE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wrMode) == 2'b10 && $past(wrAddr) >= FIRST_RW
     && $past(rdAddrA) == $past(wrAddr) && rdAddrA == $past(wrAddr))
    |-> (rdDataA[HALF-1:0] == $past(wrData[HALF-1:0])
         && rdDataA[DATA_W-1:HALF] == $past(rdDataA[DATA_W-1:HALF]))); // R6
  AST_HIGH_LANE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wrMode) == 2'b11 && $past(wrAddr) >= FIRST_RW
     && $past(rdAddrA) == $past(wrAddr) && rdAddrA == $past(wrAddr))
    |-> (rdDataA[DATA_W-1:HALF] == $past(wrData[DATA_W-1:HALF])
         && rdDataA[HALF-1:0] == $past(rdDataA[HALF-1:0]))); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wrMode) == 2'b00 && rdAddrA == $past(rdAddrA))
    |-> $stable(rdDataA)); // R4
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && rdAddrA != ADDR_W'(1)) |-> (rdDataA == '0)); // R9

endmodule

bind rf_const_regfile rf_const_regfile_chk #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .CONST_REGS(CONST_REGS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wrMode(wrMode), .wrAddr(wrAddr), .wrData(wrData),
  .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB)
);

// File: tb/rf_const_regfile_bench.sv
`timescale 1ns/1ps
module rf_const_regfile_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  wrMode = 2'b00;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [2:0]  rdAddrA = '0;
  logic [2:0]  rdAddrB = '0;
  logic [15:0] rdDataA;
  logic [15:0] rdDataB;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;
  logic [15:0] model [8];

  always #2.5 clk = ~clk;

  rf_const_regfile u_rf_const_regfile (
    .clk(clk), .rst(rst), .wrMode(wrMode), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB)
  );

  function automatic logic [15:0] expect_of(input logic [2:0] a);
    if (a == 3'd0) return 16'h0000;
    if (a == 3'd1) return 16'h0001;
    return model[a];
  endfunction

  task automatic check(input logic [2:0] a, input logic [15:0] got, input string tag);
    logic [15:0] exp;
    string t;
    exp = expect_of(a);
    t = (a == 3'd0) ? "R2" : (a == 3'd1) ? "R3" : tag;
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s row %0d: got %h expected %h", t, a, got, exp);
    end
  endtask

  // Drive one cycle; read ports are checked before the edge (old values, R8)
  task automatic apply(input logic r, input logic [1:0] m, input logic [2:0] wa,
                       input logic [15:0] wd, input logic [2:0] ra,
                       input logic [2:0] rb, input string tag);
    @(negedge clk);
    rst = r; wrMode = m; wrAddr = wa; wrData = wd; rdAddrA = ra; rdAddrB = rb;
    #1;
    check(ra, rdDataA, tag);
    check(rb, rdDataB, tag);
    @(posedge clk);
    if (r) begin
      for (int i = 2; i < 8; i++) model[i] = 16'h0000;
    end else if (wa >= 3'd2) begin
      case (m)
        2'b01: model[wa] = wd;
        2'b10: model[wa][7:0] = wd[7:0];
        2'b11: model[wa][15:8] = wd[15:8];
        default: ;
      endcase
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 16'h0000;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    // R9: reset state on every row through both ports
    for (int i = 0; i < 8; i += 2) apply(0, 2'b00, 3'd0, 16'h0, 3'(i), 3'(i + 1), "R9");
    // R5 word writes; same-cycle read of the target shows old value (R8)
    for (int i = 2; i < 8; i++)
      apply(0, 2'b01, 3'(i), 16'h1111 * 16'(i) ^ 16'h5A00, 3'(i), 3'(i), "R8");
    for (int i = 2; i < 8; i += 2) apply(0, 2'b00, 3'd0, 16'h0, 3'(i), 3'(i + 1), "R5");
    // R2 / R3: every mode aimed at constant rows
    for (int m = 1; m < 4; m++) begin
      apply(0, 2'(m), 3'd0, 16'hFFFF, 3'd0, 3'd1, "R2");
      apply(0, 2'(m), 3'd1, 16'hABCD, 3'd0, 3'd1, "R3");
    end
    apply(0, 2'b00, 3'd0, 16'h0, 3'd0, 3'd1, "R3");
    // R6 low byte
    apply(0, 2'b10, 3'd3, 16'hEE77, 3'd3, 3'd2, "R6");
    apply(0, 2'b00, 3'd0, 16'h0, 3'd3, 3'd3, "R6");
    // R7 high byte
    apply(0, 2'b11, 3'd4, 16'h9C11, 3'd4, 3'd3, "R7");
    apply(0, 2'b00, 3'd0, 16'h0, 3'd4, 3'd4, "R7");
    // R4 idle mode with busy data/address
    apply(0, 2'b00, 3'd5, 16'hDEAD, 3'd5, 3'd6, "R4");
    apply(0, 2'b00, 3'd6, 16'hBEEF, 3'd5, 3'd6, "R4");
    apply(0, 2'b00, 3'd0, 16'h0, 3'd5, 3'd6, "R4");
    // R9 reset wins over simultaneous write
    apply(1, 2'b01, 3'd7, 16'h7777, 3'd7, 3'd2, "R9");
    for (int i = 0; i < 8; i += 2) apply(0, 2'b00, 3'd0, 16'h0, 3'(i), 3'(i + 1), "R9");
    // R1 mixed traffic on both ports
    for (int n = 0; n < 300; n++)
      apply(($urandom_range(0, 40) == 0), 2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
            16'($urandom), 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), "R1");
    apply(0, 2'b00, 3'd0, 16'h0, 3'd2, 3'd7, "R1");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule